// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every incoming Ethernet frame, whether its 48-bit destination address is wanted. It holds sixteen exact-match address slots and a 4096-bit multicast hash table. A lookup first compares the address against every valid slot. Only when no slot matches does it test one bit of the hash table. That bit is selected by a 12-bit index taken from the two highest address bytes, at one of four bit offsets.

A host programs the slots, the hash table and the offset mode through a single-cycle register write port. The frame parser presents the destination address together with a one-cycle valid strobe. One cycle later the block returns a registered verdict: accept or reject, whether the accept came from an exact match, and the number of the matching slot. The verdict is also gated by three qualifying inputs: link up, receive enable and bus-master enable.

Top module: `rx_dest_filter`

## Requirements
- R1: Writes use `wr_addr[8:7]` as target (0 = slot low word, 1 = slot high word, 2 = hash word, 3 = offset mode) and `wr_addr[6:0]` as index. A slot's low word holds address bytes 0..3, with byte 0 in bits 7:0. Its high word holds bytes 4 and 5 in bits 15:0 and its valid flag in bit 31. Address byte k is `dst_addr[8k+7:8k]`.
- R2: A slot whose valid flag is clear never produces a match, whatever address it holds.
- R3: When a valid slot equals all six address bytes, the frame is accepted with `res_exact` = 1, whatever the hash table holds.
- R4: When several valid slots match, `res_slot` reports the lowest-numbered one.
- R5: The hash index is the low 12 bits of {byte 5, byte 4} shifted right by 4, 3, 2 or 0 for offset mode 0, 1, 2 or 3. The mode is written from `wr_data[1:0]`.
- R6: Without an exact match, the frame is accepted with `res_exact` = 0 exactly when hash word index[11:5], bit index[4:0], is set.
- R7: If `link_up`, `rx_en` or `bus_master` is low when the strobe is sampled, the frame is rejected.
- R8: `res_valid` is high exactly in the cycle after a cycle with `addr_valid` high. While `res_valid` is low, `res_accept` and `res_exact` are low.
- R9: A register write in the same cycle as a lookup affects only later lookups.
- R10: After reset all slots are invalid, the hash table is clear and the mode is 0, so every frame is rejected.
- R11: `res_slot` is 0 whenever `res_exact` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Write target and index |
| wr_data | input | 32 | Write data |
| link_up | input | 1 | Link is up |
| rx_en | input | 1 | Reception enabled |
| bus_master | input | 1 | Bus mastering enabled |
| addr_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_exact | output | 1 | Accept came from an exact-match slot |
| res_slot | output | 4 | Matching slot number |

## Verification
The hardest case to reach from the ports is a write and a lookup in the same clock that disagree. In that case the verdict must follow the table as it stood before the edge. The bench arranges this twice. It writes a slot's valid high word exactly in the lookup cycle and expects a reject, then a match on the next lookup. It also clears a matching slot in the lookup cycle and expects an accept, then a reject. The offset modes are told apart by one address whose index lands on a different hash word in each mode, with the hash bits set one mode at a time.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;
  typedef enum logic [1:0] {
    TGT_SLOT_LO = 2'd0,
    TGT_SLOT_HI = 2'd1,
    TGT_HASH    = 2'd2,
    TGT_MODE    = 2'd3
  } wr_tgt_e;

  localparam int SLOT_VALID_BIT = 31;
  localparam int MODE_W         = 2;
  localparam int KEY_W          = 16;
endpackage

// File: rtl/dest_slot_bank.sv
module dest_slot_bank #(
  parameter int NUM_SLOTS  = 16,
  parameter int SLOT_IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo_en,
  input  logic                  wr_hi_en,
  input  logic [SLOT_IDX_W-1:0] wr_slot,
  input  logic [31:0]           wr_lo_d,
  input  logic [16:0]           wr_hi_d,
  input  logic [47:0]           key_addr,
  output logic                  hit,
  output logic [SLOT_IDX_W-1:0] hit_idx
);
  logic [31:0]          lo_q   [NUM_SLOTS];
  logic [15:0]          hi_q   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] live_q;
  logic [NUM_SLOTS-1:0] match;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic lo_ce, hi_ce;
    assign lo_ce = wr_lo_en && (wr_slot == SLOT_IDX_W'(s));
    assign hi_ce = wr_hi_en && (wr_slot == SLOT_IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[s]   <= '0;
        hi_q[s]   <= '0;
        live_q[s] <= 1'b0;
      end else begin
        if (lo_ce) lo_q[s] <= wr_lo_d;
        if (hi_ce) begin
          hi_q[s]   <= wr_hi_d[15:0];
          live_q[s] <= wr_hi_d[16];
        end
      end
    end

    assign match[s] = live_q[s] && (lo_q[s] == key_addr[31:0]) &&
                      (hi_q[s] == key_addr[47:32]);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = SLOT_IDX_W'(i);
    end
  end
endmodule

// File: rtl/dest_hash_table.sv
module dest_hash_table
  import rx_dest_filter_pkg::*;
#(
  parameter int HASH_BITS  = 12,
  parameter int WORD_W     = 32,
  parameter int BIT_IDX_W  = $clog2(WORD_W),
  parameter int WORD_IDX_W = HASH_BITS - BIT_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_word_en,
  input  logic [WORD_IDX_W-1:0] wr_word,
  input  logic [WORD_W-1:0]     wr_d,
  input  logic                  wr_mode_en,
  input  logic [MODE_W-1:0]     wr_mode_d,
  input  logic [KEY_W-1:0]      key,
  output logic                  hit
);
  localparam int NUM_WORDS = 2 ** WORD_IDX_W;

  logic [WORD_W-1:0]    tbl_q [NUM_WORDS];
  logic [MODE_W-1:0]    mode_q;
  logic [KEY_W-1:0]     shifted;
  logic [HASH_BITS-1:0] hidx;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic ce;
    assign ce = wr_word_en && (wr_word == WORD_IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbl_q[w] <= '0;
      else if (ce) tbl_q[w] <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= '0;
    else if (wr_mode_en) mode_q <= wr_mode_d;
  end

  always_comb begin
    case (mode_q)
      2'd0:    shifted = key >> 4;
      2'd1:    shifted = key >> 3;
      2'd2:    shifted = key >> 2;
      default: shifted = key;
    endcase
    hidx = shifted[HASH_BITS-1:0];
    hit  = tbl_q[hidx[HASH_BITS-1:BIT_IDX_W]][hidx[BIT_IDX_W-1:0]];
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter  int NUM_SLOTS  = 16,
  parameter  int HASH_BITS  = 12,
  parameter  int WORD_W     = 32,
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS),
  localparam int BIT_IDX_W  = $clog2(WORD_W),
  localparam int WORD_IDX_W = HASH_BITS - BIT_IDX_W,
  localparam int WR_IDX_W   = (WORD_IDX_W > SLOT_IDX_W) ? WORD_IDX_W : SLOT_IDX_W,
  localparam int WR_ADDR_W  = WR_IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WR_ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  link_up,
  input  logic                  rx_en,
  input  logic                  bus_master,
  input  logic                  addr_valid,
  input  logic [47:0]           dst_addr,
  output logic                  res_valid,
  output logic                  res_accept,
  output logic                  res_exact,
  output logic [SLOT_IDX_W-1:0] res_slot
);
  wr_tgt_e               tgt;
  logic [WR_IDX_W-1:0]   wr_idx;
  logic                  slot_hit, hash_hit, rx_ok;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic                  valid_d, accept_d, exact_d;
  logic [SLOT_IDX_W-1:0] slot_d;

  assign tgt    = wr_tgt_e'(wr_addr[WR_ADDR_W-1 -: 2]);
  assign wr_idx = wr_addr[WR_IDX_W-1:0];

  dest_slot_bank #(
    .NUM_SLOTS  (NUM_SLOTS),
    .SLOT_IDX_W (SLOT_IDX_W)
  ) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo_en (wr_en && (tgt == TGT_SLOT_LO)),
    .wr_hi_en (wr_en && (tgt == TGT_SLOT_HI)),
    .wr_slot  (wr_idx[SLOT_IDX_W-1:0]),
    .wr_lo_d  (wr_data[31:0]),
    .wr_hi_d  ({wr_data[SLOT_VALID_BIT], wr_data[15:0]}),
    .key_addr (dst_addr),
    .hit      (slot_hit),
    .hit_idx  (slot_idx)
  );

  dest_hash_table #(
    .HASH_BITS (HASH_BITS),
    .WORD_W    (WORD_W)
  ) u_hash (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_word_en (wr_en && (tgt == TGT_HASH)),
    .wr_word    (wr_idx[WORD_IDX_W-1:0]),
    .wr_d       (wr_data),
    .wr_mode_en (wr_en && (tgt == TGT_MODE)),
    .wr_mode_d  (wr_data[MODE_W-1:0]),
    .key        (dst_addr[47:32]),
    .hit        (hash_hit)
  );

  assign rx_ok = link_up && rx_en && bus_master;

  always_comb begin
    valid_d  = addr_valid;
    accept_d = 1'b0;
    exact_d  = 1'b0;
    slot_d   = '0;
    if (addr_valid && rx_ok) begin
      if (slot_hit) begin
        accept_d = 1'b1;
        exact_d  = 1'b1;
        slot_d   = slot_idx;
      end else begin
        accept_d = hash_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_exact  <= 1'b0;
      res_slot   <= '0;
    end else begin
      res_valid  <= valid_d;
      res_accept <= accept_d;
      res_exact  <= exact_d;
      res_slot   <= slot_d;
    end
  end
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
  parameter int SLOT_IDX_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  link_up,
  input logic                  rx_en,
  input logic                  bus_master,
  input logic                  addr_valid,
  input logic                  res_valid,
  input logic                  res_accept,
  input logic                  res_exact,
  input logic [SLOT_IDX_W-1:0] res_slot
);
  AST_GATED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !(link_up && rx_en && bus_master)) |=> !res_accept); // R7
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> res_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !res_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_accept && !res_exact)); // R8
  AST_EXACT_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    res_exact |-> res_accept); // R3
  AST_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_exact |-> (res_slot == '0)); // R11
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.SLOT_IDX_W(SLOT_IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_up    (link_up),
  .rx_en      (rx_en),
  .bus_master (bus_master),
  .addr_valid (addr_valid),
  .res_valid  (res_valid),
  .res_accept (res_accept),
  .res_exact  (res_exact),
  .res_slot   (res_slot)
);

// File: tb/sim_rx_dest_filter.sv
module sim_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        link_up = 1'b1, rx_en = 1'b1, bus_master = 1'b1;
  logic        addr_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        res_valid, res_accept, res_exact;
  logic [3:0]  res_slot;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rx_dest_filter u0 (.*);

  localparam logic [47:0] A0  = 48'h5544_3322_1100;
  localparam logic [47:0] A3  = 48'hBEEF_DEAD_0102;
  localparam logic [47:0] A7  = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] A15 = 48'h1234_5678_9ABC;
  localparam logic [47:0] H1  = 48'h1234_0000_0001;
  localparam logic [47:0] AN  = 48'h0000_0000_7777;

  // vector: address, accept, exact, slot
  typedef struct packed {
    logic [47:0] a;
    logic        acc;
    logic        ex;
    logic [3:0]  sl;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{A0,  1'b1, 1'b1, 4'd0},                  // R3
    '{A3,  1'b1, 1'b1, 4'd3},                  // R4 slot 5 holds same
    '{A7,  1'b0, 1'b0, 4'd0},                  // R2 invalid slot
    '{A15, 1'b1, 1'b1, 4'd15},                 // R1 layout
    '{H1,  1'b1, 1'b0, 4'd0},                  // R6 hash word 9 bit 3
    '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 4'd0},   // R6 unset bit
    '{48'h5544_3322_1101, 1'b0, 1'b0, 4'd0},   // R3 one byte off
    '{48'h5545_3322_1100, 1'b0, 1'b0, 4'd0}    // R3 high byte off
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid/acc/ex/slot=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] tgt, input logic [6:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {tgt, idx}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_slot(input int s, input logic [47:0] a, input logic v);
    wr(2'd0, 7'(s), a[31:0]);
    wr(2'd1, 7'(s), {v, 15'd0, a[47:32]});
  endtask

  task automatic look(input string req, input logic [47:0] a,
                      input logic acc, input logic ex, input logic [3:0] sl);
    @(negedge clk);
    addr_valid = 1'b1; dst_addr = a;
    @(negedge clk);
    addr_valid = 1'b0;
    check(req, {res_valid, res_accept, res_exact, res_slot}, {1'b1, acc, ex, sl});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state and empty tables
    @(negedge clk);
    check("R10 idle", {res_valid, res_accept, res_exact, res_slot}, 7'b0);
    look("R10 empty", A0, 1'b0, 1'b0, 4'd0);
    // R8 no strobe -> no result
    @(negedge clk);
    check("R8 quiet", {res_valid, res_accept, res_exact, res_slot}, 7'b0);

    set_slot(0, A0, 1'b1);
    set_slot(3, A3, 1'b1);
    set_slot(5, A3, 1'b1);
    set_slot(7, A7, 1'b0);
    set_slot(15, A15, 1'b1);
    wr(2'd2, 7'd9, 32'h0000_0008);   // mode 0: 0x1234>>4 = 0x123

    for (int i = 0; i < NV; i++)
      look("R1..R6 table", VECS[i].a, VECS[i].acc, VECS[i].ex, VECS[i].sl);

    // R3 exact wins even when hash bit for the address is set: A0 mode0 idx 0x554
    wr(2'd2, 7'd42, 32'h0010_0000);
    look("R3 exact over hash", A0, 1'b1, 1'b1, 4'd0);
    look("R6 hash only", 48'h5544_0000_0000, 1'b1, 1'b0, 4'd0);
    wr(2'd2, 7'd42, 32'h0);

    // R7 gating
    link_up = 1'b0;    look("R7 link", A0, 1'b0, 1'b0, 4'd0); link_up = 1'b1;
    rx_en = 1'b0;      look("R7 rxen", H1, 1'b0, 1'b0, 4'd0); rx_en = 1'b1;
    bus_master = 1'b0; look("R7 master", A15, 1'b0, 1'b0, 4'd0); bus_master = 1'b1;

    // R5 offset modes with H1 (key 0x1234)
    wr(2'd3, 7'd0, 32'd1);           // >>3 -> 0x246 word 18 bit 6
    look("R5 mode1 unset", H1, 1'b0, 1'b0, 4'd0);
    wr(2'd2, 7'd18, 32'h0000_0040);
    look("R5 mode1", H1, 1'b1, 1'b0, 4'd0);
    wr(2'd3, 7'd0, 32'd2);           // >>2 -> 0x48D word 36 bit 13
    look("R5 mode2 unset", H1, 1'b0, 1'b0, 4'd0);
    wr(2'd2, 7'd36, 32'h0000_2000);
    look("R5 mode2", H1, 1'b1, 1'b0, 4'd0);
    wr(2'd3, 7'd0, 32'd3);           // >>0 -> 0x234 word 17 bit 20
    look("R5 mode3 unset", H1, 1'b0, 1'b0, 4'd0);
    wr(2'd2, 7'd17, 32'h0010_0000);
    look("R5 mode3", H1, 1'b1, 1'b0, 4'd0);

    // R9 write in lookup cycle: enable slot 1
    wr(2'd0, 7'd1, AN[31:0]);
    @(negedge clk);
    addr_valid = 1'b1; dst_addr = AN;
    wr_en = 1'b1; wr_addr = {2'd1, 7'd1}; wr_data = {1'b1, 15'd0, AN[47:32]};
    @(negedge clk);
    addr_valid = 1'b0; wr_en = 1'b0;
    check("R9 old view", {res_valid, res_accept, res_exact, res_slot}, {1'b1, 1'b0, 1'b0, 4'd0});
    look("R9 new view", AN, 1'b1, 1'b1, 4'd1);
    // R9 invalidate slot 0 in lookup cycle
    @(negedge clk);
    addr_valid = 1'b1; dst_addr = A0;
    wr_en = 1'b1; wr_addr = {2'd1, 7'd0}; wr_data = {16'd0, A0[47:32]};
    @(negedge clk);
    addr_valid = 1'b0; wr_en = 1'b0;
    check("R9 still old", {res_valid, res_accept, res_exact, res_slot}, {1'b1, 1'b1, 1'b1, 4'd0});
    look("R2 cleared slot", A0, 1'b0, 1'b0, 4'd0);

    // R10 reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 in reset", {res_valid, res_accept, res_exact, res_slot}, 7'b0);
    rst_n = 1'b1;
    look("R10 slots cleared", A15, 1'b0, 1'b0, 4'd0);
    look("R10 hash cleared", H1, 1'b0, 1'b0, 4'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule